// File: doc/BRIEF.md
# Hash input block accumulator

This block sits between a byte-stream message source and a hash compression engine that handles SHA-1 and SHA-256. A session opens with an init command that also fixes the algorithm. Each update command then announces a chunk length, and that many bytes follow on a valid/ready byte stream. The block collects bytes in a 64-byte residue buffer. It hands the engine only whole 64-byte blocks, each as one job, and carries any partial block over to the next update. The first job of a session is tagged so that the engine loads its initial chaining value.

A finish command closes the session. If no byte was ever supplied, no job is issued and the block returns the fixed digest of the empty message. Otherwise the remaining residue, from 0 to 63 bytes, goes out as one job marked final. The engine answers with a done pulse and a digest whose bytes are in reverse order. The block puts the bytes back in order and offers the digest on a valid/ready output. Taking the digest returns the block to idle. Illegal commands are refused with a one-cycle error pulse and change nothing.

Back-pressure rules: `in_ready` is high only while an announced chunk still has bytes to come and no job is waiting. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. `job_valid` and `dig_valid` stay high, with their data unchanged, until the matching ready is seen high on an edge. The commands `init_req`, `upd_req` and `fin_req` are single-cycle strobes. If more than one is high in a cycle, init wins over update and update wins over finish. The losing strobes are ignored.

Top module: `hash_block_accum`

## Requirements
- R1: Every job that is not final carries exactly 64 bytes (`job_len` = 64). Bytes appear in arrival order, with the byte that arrived first after the previous job at `job_data[7:0]`, the next at `[15:8]`, and so on. Leftover bytes from earlier updates come before the new bytes.
- R2: Bytes that do not complete a block stay in the residue. An update that leaves a partial block issues no job for that partial block.
- R3: The first job after init has `job_first`=1, whether it is a full block or the final job. Every later job in the session has `job_first`=0.
- R4: A successful finish, unless R5 applies, issues one job with `job_final`=1 and `job_len` equal to the residue count (0 to 63). Byte lanes at or above that count are zero.
- R5: A finish with no byte ever supplied since init issues no job. It presents the empty-message digest, left-aligned in `dig_data`. With `alg_sel`=0 (SHA-1) this is da39a3ee5e6b4b0d3255bfef95601890afd80709 followed by 96 zero bits. With `alg_sel`=1 (SHA-256) it is e3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855.
- R6: The byte at `eng_result[8k+7:8k]` appears at `dig_data[255-8k -: 8]`. For SHA-1, bits [95:0] of `dig_data` are zero whatever the engine returns.
- R7: An update with `upd_len`=0 is refused with `err_code`=2 and leaves the residue untouched.
- R8: An update or finish with no open session, or an init while a session is open, is refused with `err_code`=1.
- R9: A finish whose `fin_room` is below the digest size (20 for SHA-1, 32 for SHA-256) is refused with `err_code`=2, and the session stays open.
- R10: An update whose length plus the residue count exceeds 2^LEN_W-1 is refused with `err_code`=2.
- R11: The algorithm is sampled at init. `job_alg` and the digest follow that value even if `alg_sel` changes later.
- R12: While `job_valid` or `dig_valid` is high and not yet accepted, it stays high and its data stays stable, and `in_ready` is low.
- R13: Once the digest is accepted the block is idle with an empty residue. Updates are then refused, and a new init starts a session with no stale bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Open a session (strobe) |
| alg_sel | input | 1 | 0 = SHA-1, 1 = SHA-256, sampled on init |
| upd_req | input | 1 | Announce a chunk (strobe) |
| upd_len | input | LEN_W | Byte count of the announced chunk |
| fin_req | input | 1 | Close the session (strobe) |
| fin_room | input | 6 | Size of the receiving digest buffer in bytes |
| in_valid | input | 1 | Message byte valid |
| in_ready | output | 1 | Message byte accepted |
| in_data | input | 8 | Message byte |
| job_valid | output | 1 | Job offered to engine |
| job_ready | input | 1 | Engine takes the job |
| job_data | output | 8*BLK_BYTES | Job bytes, byte i at [8i+7:8i] |
| job_len | output | clog2(BLK_BYTES+1) | Valid bytes in the job |
| job_first | output | 1 | Engine must load its initial state |
| job_final | output | 1 | Engine must pad and finish |
| job_alg | output | 1 | Algorithm of the job |
| eng_done | input | 1 | Engine digest ready (strobe) |
| eng_result | input | 256 | Engine digest, byte-reversed |
| dig_valid | output | 1 | Digest offered |
| dig_ready | input | 1 | Digest taken |
| dig_data | output | 256 | Digest, first byte at [255:248] |
| err_valid | output | 1 | Command refused (one-cycle pulse) |
| err_code | output | 2 | 1 = wrong state, 2 = bad argument |

## Verification
The bench targets the block boundary. It builds an update that ends exactly on 64 bytes, which must give one job with no leftover. It follows that with a finish on an empty residue, which must still send a zero-length final job rather than the constant digest. A design that got this wrong would either hold back a full block or return the empty-message digest for a non-empty message. A finish that comes while the first-job tag is still pending, with a few residue bytes, must carry both the first and final tags. A design that dropped one tag would hash with the wrong initial state or leave the message without padding. The bench also refuses a zero-length update, an overflowing update and a too-small digest buffer in the middle of a session, and then confirms that the residue survived. It stalls the engine and the digest consumer to check that nothing moves while back-pressured. It checks that SHA-1 digests are masked and reversed, and that a new session starts with no stale bytes.

// File: rtl/hacc_pkg.sv
package hacc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_STRM, ST_SEND, ST_WAIT, ST_OUT
  } hacc_state_e;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_STATE = 2'd1;
  localparam logic [1:0] ERR_ARG   = 2'd2;

  localparam int DIG_BYTES  = 32;
  localparam int DIG_W      = DIG_BYTES * 8;
  localparam int SHA1_BYTES = 20;

  localparam logic [5:0] NEED_SHA1   = 6'd20;
  localparam logic [5:0] NEED_SHA256 = 6'd32;

  localparam logic [DIG_W-1:0] EMPTY_SHA1 =
    {160'hda39a3ee5e6b4b0d3255bfef95601890afd80709, 96'h0};
  localparam logic [DIG_W-1:0] EMPTY_SHA256 =
    256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
endpackage

// File: rtl/hacc_resbuf.sv
module hacc_resbuf #(
  parameter int BLK_BYTES = 64,
  localparam int CNT_W = $clog2(BLK_BYTES + 1),
  localparam int IDX_W = $clog2(BLK_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_byte,
  input  logic                   clr,
  output logic [CNT_W-1:0]       fill,
  output logic [BLK_BYTES*8-1:0] flat
);
  localparam logic [CNT_W-1:0] BLK_CNT = CNT_W'(BLK_BYTES);

  logic [7:0] mem [BLK_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < BLK_BYTES; i++) mem[i] <= '0;
    end else if (clr) begin
      fill <= '0;
      for (int i = 0; i < BLK_BYTES; i++) mem[i] <= '0;
    end else if (wr_en && fill < BLK_CNT) begin
      mem[fill[IDX_W-1:0]] <= wr_byte;
      fill <= fill + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_pack
    assign flat[8*g +: 8] = mem[g];
  end

  // R1
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> fill < BLK_CNT);
endmodule

// File: rtl/hacc_digest.sv
module hacc_digest
  import hacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_const,
  input  logic             ld_eng,
  input  logic             alg,
  input  logic [DIG_W-1:0] eng_res,
  output logic [DIG_W-1:0] dig
);
  logic [DIG_W-1:0] rev;

  for (genvar k = 0; k < DIG_BYTES; k++) begin : g_rev
    if (k < SHA1_BYTES) begin : g_all
      assign rev[DIG_W-1-8*k -: 8] = eng_res[8*k +: 8];
    end else begin : g_wide
      assign rev[DIG_W-1-8*k -: 8] = alg ? eng_res[8*k +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dig <= '0;
    else if (ld_const) dig <= alg ? EMPTY_SHA256 : EMPTY_SHA1;
    else if (ld_eng)   dig <= rev;
  end

  // R5
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_const && ld_eng));
endmodule

// File: rtl/hacc_ctrl.sv
module hacc_ctrl
  import hacc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BLK_BYTES = 64,
  localparam int CNT_W = $clog2(BLK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             alg_sel,
  input  logic             upd_req,
  input  logic [LEN_W-1:0] upd_len,
  input  logic             fin_req,
  input  logic [5:0]       fin_room,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             job_valid,
  input  logic             job_ready,
  output logic             job_first,
  output logic             job_final,
  output logic             job_alg,
  input  logic             eng_done,
  output logic             dig_valid,
  input  logic             dig_ready,
  output logic             err_valid,
  output logic [1:0]       err_code,
  input  logic [CNT_W-1:0] fill,
  output logic             buf_wr,
  output logic             buf_clr,
  output logic             dig_ld_const,
  output logic             dig_ld_eng
);
  localparam logic [CNT_W-1:0] BLK_CNT  = CNT_W'(BLK_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLK_BYTES - 1);

  hacc_state_e      state;
  logic             first_q, alg_q, closing_q;
  logic [LEN_W-1:0] rem_q;

  logic             job_take, dig_take, init_ok, upd_cmd, fin_cmd;
  logic             ovf, fin_short, fin_empty;
  logic [LEN_W-1:0] space_left;

  assign in_ready  = (state == ST_STRM);
  assign job_valid = (state == ST_SEND);
  assign dig_valid = (state == ST_OUT);
  assign job_first = first_q;
  assign job_final = closing_q;
  assign job_alg   = alg_q;

  assign buf_wr   = in_valid && in_ready;
  assign job_take = job_valid && job_ready;
  assign dig_take = dig_valid && dig_ready;

  assign init_ok = init_req && (state == ST_IDLE);
  assign upd_cmd = upd_req && !init_req;
  assign fin_cmd = fin_req && !init_req && !upd_req;

  assign space_left = {LEN_W{1'b1}} - LEN_W'(fill);
  assign ovf        = upd_len > space_left;
  assign fin_short  = fin_room < (alg_q ? NEED_SHA256 : NEED_SHA1);
  assign fin_empty  = first_q && (fill == '0);

  assign buf_clr      = job_take || init_ok || dig_take;
  assign dig_ld_const = fin_cmd && (state == ST_ACT) && !fin_short && fin_empty;
  assign dig_ld_eng   = (state == ST_WAIT) && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      first_q   <= 1'b0;
      alg_q     <= 1'b0;
      closing_q <= 1'b0;
      rem_q     <= '0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
      if (init_req) begin
        if (init_ok) begin
          alg_q   <= alg_sel;
          first_q <= 1'b1;
          state   <= ST_ACT;
        end else begin
          err_valid <= 1'b1;
          err_code  <= ERR_STATE;
        end
      end else if (upd_cmd) begin
        if (state != ST_ACT) begin
          err_valid <= 1'b1;
          err_code  <= ERR_STATE;
        end else if (upd_len == '0 || ovf) begin
          err_valid <= 1'b1;
          err_code  <= ERR_ARG;
        end else begin
          rem_q <= upd_len;
          state <= ST_STRM;
        end
      end else if (fin_cmd) begin
        if (state != ST_ACT) begin
          err_valid <= 1'b1;
          err_code  <= ERR_STATE;
        end else if (fin_short) begin
          err_valid <= 1'b1;
          err_code  <= ERR_ARG;
        end else if (fin_empty) begin
          state <= ST_OUT;
        end else begin
          closing_q <= 1'b1;
          state     <= ST_SEND;
        end
      end

      case (state)
        ST_STRM: if (buf_wr) begin
          rem_q <= rem_q - LEN_W'(1);
          if (fill == LAST_CNT)          state <= ST_SEND;
          else if (rem_q == LEN_W'(1))   state <= ST_ACT;
        end
        ST_SEND: if (job_ready) begin
          first_q <= 1'b0;
          if (closing_q)          state <= ST_WAIT;
          else if (rem_q == '0)   state <= ST_ACT;
          else                    state <= ST_STRM;
        end
        ST_WAIT: if (eng_done) state <= ST_OUT;
        ST_OUT: if (dig_ready) begin
          state     <= ST_IDLE;
          closing_q <= 1'b0;
          first_q   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R12
  job_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid);
  // R12
  dig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid && !dig_ready |=> dig_valid);
  // R1
  short_job_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && (fill != BLK_CNT) |-> job_final);
  // R3
  first_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_ready |=> !job_first);
  // R2
  act_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT) |-> fill < BLK_CNT);
  // R11
  alg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && $past(state != ST_IDLE) |-> $stable(alg_q));
endmodule

// File: rtl/hash_block_accum.sv
module hash_block_accum
  import hacc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BLK_BYTES = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             init_req,
  input  logic                             alg_sel,
  input  logic                             upd_req,
  input  logic [LEN_W-1:0]                 upd_len,
  input  logic                             fin_req,
  input  logic [5:0]                       fin_room,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [7:0]                       in_data,
  output logic                             job_valid,
  input  logic                             job_ready,
  output logic [BLK_BYTES*8-1:0]           job_data,
  output logic [$clog2(BLK_BYTES+1)-1:0]   job_len,
  output logic                             job_first,
  output logic                             job_final,
  output logic                             job_alg,
  input  logic                             eng_done,
  input  logic [255:0]                     eng_result,
  output logic                             dig_valid,
  input  logic                             dig_ready,
  output logic [255:0]                     dig_data,
  output logic                             err_valid,
  output logic [1:0]                       err_code
);
  localparam int CNT_W = $clog2(BLK_BYTES + 1);

  logic [CNT_W-1:0] fill;
  logic buf_wr, buf_clr, ld_const, ld_eng;

  hacc_ctrl #(.LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .init_req(init_req), .alg_sel(alg_sel),
    .upd_req(upd_req), .upd_len(upd_len),
    .fin_req(fin_req), .fin_room(fin_room),
    .in_valid(in_valid), .in_ready(in_ready),
    .job_valid(job_valid), .job_ready(job_ready),
    .job_first(job_first), .job_final(job_final), .job_alg(job_alg),
    .eng_done(eng_done),
    .dig_valid(dig_valid), .dig_ready(dig_ready),
    .err_valid(err_valid), .err_code(err_code),
    .fill(fill), .buf_wr(buf_wr), .buf_clr(buf_clr),
    .dig_ld_const(ld_const), .dig_ld_eng(ld_eng)
  );

  hacc_resbuf #(.BLK_BYTES(BLK_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_wr), .wr_byte(in_data), .clr(buf_clr),
    .fill(fill), .flat(job_data)
  );

  hacc_digest u_dig (
    .clk(clk), .rst_n(rst_n),
    .ld_const(ld_const), .ld_eng(ld_eng), .alg(job_alg),
    .eng_res(eng_result), .dig(dig_data)
  );

  assign job_len = fill;
endmodule

// File: tb/test_hash_block_accum.sv
module test_hash_block_accum;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 0, alg_sel = 0, upd_req = 0, fin_req = 0;
  logic [15:0] upd_len = '0;
  logic [5:0] fin_room = '0;
  logic in_valid = 0, job_ready = 1, eng_done = 0, dig_ready = 0;
  logic [7:0] in_data = '0;
  logic [255:0] eng_result = '0;
  logic in_ready, job_valid, job_first, job_final, job_alg, dig_valid, err_valid;
  logic [511:0] job_data;
  logic [6:0] job_len;
  logic [255:0] dig_data;
  logic [1:0] err_code;

  int n_chk = 0, n_bad = 0, njobs = 0;
  logic [511:0] cj_data [16];
  logic [6:0]   cj_len  [16];
  logic [2:0]   cj_flag [16];

  hash_block_accum i_hash_block_accum (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .alg_sel(alg_sel),
    .upd_req(upd_req), .upd_len(upd_len), .fin_req(fin_req), .fin_room(fin_room),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .job_valid(job_valid), .job_ready(job_ready), .job_data(job_data),
    .job_len(job_len), .job_first(job_first), .job_final(job_final),
    .job_alg(job_alg), .eng_done(eng_done), .eng_result(eng_result),
    .dig_valid(dig_valid), .dig_ready(dig_ready), .dig_data(dig_data),
    .err_valid(err_valid), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && job_valid && job_ready) begin
      if (njobs < 16) begin
        cj_data[njobs] = job_data;
        cj_len[njobs]  = job_len;
        cj_flag[njobs] = {job_first, job_final, job_alg};
      end
      njobs = njobs + 1;
    end
  end

  function automatic logic [7:0] bv(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [255:0] exp_dig(input logic [255:0] v, input logic alg);
    logic [255:0] e = '0;
    for (int k = 0; k < 32; k++)
      if (alg || k < 20) e[255-8*k -: 8] = v[8*k +: 8];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (job_valid || in_ready) @(negedge clk);
  endtask

  task automatic chk_err(input string tag, input logic [1:0] code);
    chk(tag, {err_valid, err_code}, {(code != 2'd0), code});
  endtask

  task automatic cmd_init(input logic alg, input logic [1:0] code, input string tag);
    wait_quiet();
    init_req = 1; alg_sel = alg;
    @(negedge clk);
    init_req = 0;
    chk_err(tag, code);
  endtask

  task automatic cmd_upd(input int len, input logic [1:0] code, input string tag);
    wait_quiet();
    upd_req = 1; upd_len = 16'(len);
    @(negedge clk);
    upd_req = 0;
    chk_err(tag, code);
  endtask

  task automatic cmd_fin(input int room, input logic [1:0] code, input string tag);
    wait_quiet();
    fin_req = 1; fin_room = 6'(room);
    @(negedge clk);
    fin_req = 0;
    chk_err(tag, code);
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_upd(input int len, input int base, input string tag);
    cmd_upd(len, 2'd0, tag);
    for (int i = 0; i < len; i++) push_byte(bv(base + i));
  endtask

  task automatic wait_jobs(input int n, input string tag);
    int k = 0;
    while (njobs < n && k < 40) begin @(negedge clk); k++; end
    chk(tag, 512'(njobs), 512'(n));
  endtask

  task automatic chk_job(input int idx, input int len, input logic first, input logic fin,
                         input logic alg, input int base, input string tag);
    logic [511:0] e = '0;
    for (int i = 0; i < len; i++) e[8*i +: 8] = bv(base + i);
    if (idx >= njobs || idx >= 16) begin
      chk({tag, " present"}, 512'(njobs), 512'(idx + 1));
    end else begin
      chk({tag, " data"}, cj_data[idx], e);
      chk({tag, " len"}, 512'(cj_len[idx]), 512'(len));
      chk({tag, " flags"}, 512'(cj_flag[idx]), 512'({first, fin, alg}));
    end
  endtask

  task automatic eng_reply(input logic [255:0] v);
    @(negedge clk);
    eng_done = 1; eng_result = v;
    @(negedge clk);
    eng_done = 0;
  endtask

  task automatic take_digest(input logic [255:0] e, input string tag);
    int k = 0;
    @(negedge clk);
    while (!dig_valid && k < 40) begin @(negedge clk); k++; end
    chk({tag, " dig_valid"}, 512'(dig_valid), 512'(1));
    chk({tag, " dig_data"}, 512'(dig_data), 512'(e));
    dig_ready = 1;
    @(negedge clk);
    dig_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 reset outputs", 512'({in_ready, job_valid, dig_valid, err_valid}), 512'(0));
  endtask

  task automatic t_pre_init();
    cmd_upd(5, 2'd1, "R8 update before init");
    cmd_fin(32, 2'd1, "R8 finish before init");
  endtask

  task automatic t_empty();
    int j0 = njobs;
    cmd_init(1'b0, 2'd0, "R5 init sha1");
    cmd_fin(20, 2'd0, "R5 fin sha1");
    take_digest({160'hda39a3ee5e6b4b0d3255bfef95601890afd80709, 96'h0}, "R5 empty sha1");
    cmd_init(1'b1, 2'd0, "R5 init sha256");
    cmd_fin(32, 2'd0, "R5 fin sha256");
    take_digest(256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855,
                "R5 empty sha256");
    chk("R5 no job issued", 512'(njobs), 512'(j0));
  endtask

  task automatic t_multi();
    int j0 = njobs;
    logic [255:0] v = 256'h0123456789abcdeffedcba9876543210_1122334455667788_99aabbccddeeff00;
    cmd_init(1'b1, 2'd0, "R11 init sha256");
    alg_sel = 0;
    send_upd(10, 0, "R2 upd10");
    wait_quiet();
    chk("R2 partial gives no job", 512'(njobs), 512'(j0));
    send_upd(100, 10, "R1 upd100");
    wait_jobs(j0 + 1, "R1 one block");
    chk_job(j0, 64, 1'b1, 1'b0, 1'b1, 0, "R1 R3 R11 job0");
    send_upd(18, 110, "R2 upd18");
    wait_jobs(j0 + 2, "R2 block from residue");
    chk_job(j0 + 1, 64, 1'b0, 1'b0, 1'b1, 64, "R2 R3 job1");
    send_upd(5, 128, "R2 upd5");
    cmd_fin(32, 2'd0, "R4 fin");
    wait_jobs(j0 + 3, "R4 final job");
    chk_job(j0 + 2, 5, 1'b0, 1'b1, 1'b1, 128, "R4 job2");
    eng_reply(v);
    take_digest(exp_dig(v, 1'b1), "R6 R11 sha256 reverse");
  endtask

  task automatic t_errors();
    int j0 = njobs;
    logic [255:0] v = 256'hfedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0_55aa55aa33cc33cc;
    cmd_init(1'b0, 2'd0, "R8 init");
    cmd_init(1'b1, 2'd1, "R8 init while open");
    cmd_upd(0, 2'd2, "R7 zero length");
    send_upd(3, 200, "R7 upd3");
    cmd_upd(16'hFFFF, 2'd2, "R10 overflow");
    cmd_fin(19, 2'd2, "R9 small room");
    cmd_fin(20, 2'd0, "R9 fin ok");
    wait_jobs(j0 + 1, "R4 final job");
    chk_job(j0, 3, 1'b1, 1'b1, 1'b0, 200, "R3 R4 R7 R11 first and final");
    eng_reply(v);
    take_digest(exp_dig(v, 1'b0), "R6 sha1 mask");
    cmd_upd(4, 2'd1, "R13 update after finish");
  endtask

  task automatic t_backpress();
    int j0 = njobs;
    logic [511:0] held;
    logic [255:0] dh;
    logic [255:0] v = 256'h00112233445566778899aabbccddeeff_102132435465768798a9bacbdcedfe0f;
    logic [255:0] w = 256'h0badc0de_00000000_0000000000000000_00000000_00000000_0000_cafe_f00d;
    job_ready = 0;
    cmd_init(1'b1, 2'd0, "R12 init");
    send_upd(64, 0, "R12 upd64");
    chk("R12 job pending", 512'({job_valid, in_ready}), 512'(2'b10));
    held = job_data;
    @(negedge clk); @(negedge clk);
    chk("R12 job held", 512'({job_valid, in_ready}), 512'(2'b10));
    chk("R12 job data stable", job_data, held);
    job_ready = 1;
    wait_jobs(j0 + 1, "R1 exact block");
    chk_job(j0, 64, 1'b1, 1'b0, 1'b1, 0, "R1 R3 job exact");
    cmd_fin(32, 2'd0, "R4 fin empty residue");
    wait_jobs(j0 + 2, "R4 zero length final");
    chk_job(j0 + 1, 0, 1'b0, 1'b1, 1'b1, 0, "R4 job empty final");
    eng_reply(v);
    @(negedge clk);
    dh = dig_data;
    @(negedge clk); @(negedge clk);
    chk("R12 dig held", 512'(dig_valid), 512'(1));
    chk("R12 dig stable", 512'(dig_data), 512'(dh));
    take_digest(exp_dig(v, 1'b1), "R6 bp digest");
    cmd_init(1'b0, 2'd0, "R13 reinit");
    send_upd(2, 50, "R13 upd2");
    cmd_fin(32, 2'd0, "R13 fin");
    wait_jobs(j0 + 3, "R13 job");
    chk_job(j0 + 2, 2, 1'b1, 1'b1, 1'b0, 50, "R13 fresh session");
    eng_reply(w);
    take_digest(exp_dig(w, 1'b0), "R13 R6 digest");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_pre_init();
    t_empty();
    t_multi();
    t_errors();
    t_backpress();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule